// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between DMA-capable devices and main memory and turns each device-issued virtual address into a physical one. Translations live in a page table of 32-bit entries in memory. A small fully associative translation cache keeps recently used entries. On a cache miss the block reads the entry from memory, checks it, caches it and answers. A register port sets the translation enable and window size, gives the page table location, and exposes two write-only invalidation registers: one clears everything, one clears a single page.

Each of the device slots has its own configuration word. Setting its pass-through bit makes that slot's addresses physical, with address bit 30 taken from the same word. The translation window always ends at the top of the 32-bit address space, and its size is chosen from a 3-bit code. An access outside the window, a missing mapping, or a write to a read-only page yields a single-cycle fault pulse and no address.

Top module: `io_xlate_unit`

## Requirements
- R1: After reset, the control, base and slot registers read as zero, `reqReady` is high, and `respValid`, `respFault` and `memRdValid` are low. The translation cache starts empty, so the first translated access issues a memory read.
- R2: Register offset 0 is control. Bit 0 enables translation and bits 4:2 hold the window code. It reads back those fields and zeros elsewhere. Offset 1 is the page table base and reads back all 32 bits. Offsets 2 and 3 read as zero.
- R3: The configuration word of slot s is at offset 4+s. Bit 0 selects pass-through, bit 16 supplies physical bit 30, and bits 1 and 2 are burst capability flags. These four bits read back and all others read 0. In pass-through the physical address is {0, bit16, va[29:0]}, whatever the enable and window settings. The burst flags have no effect on the result.
- R4: With translation disabled and the slot not in pass-through, the physical address is va with bit 31 cleared, and the cacheable flag is 0.
- R5: With translation enabled, the window starts at 0xFFFFFFFF shifted left by 24+code. An address below the start gives a fault pulse one cycle after acceptance and no memory read.
- R6: On a miss, `memRdValid` rises in the cycle after acceptance with `memRdAddr` = base + ((va − start) >> 12) × 4. Both stay stable until `memRspValid` is sampled. The response follows one cycle after that.
- R7: A fetched or cached entry gives physical address {0, entry[26:8], va[11:0]}. Entry bit 7 drives `respCacheable`, bit 2 grants write and bit 1 marks the entry valid.
- R8: An entry with bit 1 clear gives a fault and is not cached, so a repeat access fetches it again.
- R9: A write through an entry whose bit 2 is clear gives a fault. A read through the same entry succeeds, and the entry stays cached.
- R10: A cache hit answers one cycle after acceptance and issues no memory read.
- R11: The cache holds 8 entries filled in round-robin order, so the ninth distinct page evicts the first one filled.
- R12: A write of any data to offset 2 invalidates every cached translation.
- R13: A write to offset 3 invalidates only the cached page equal to the written value's bits 31:12.
- R14: An invalidation written while a fetch is outstanding still lets that fetch answer, but the fetched entry is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Block can accept a request |
| reqSlot | input | 2 | Requesting device slot |
| reqVa | input | 32 | Virtual address |
| reqWrite | input | 1 | Request is a write |
| respValid | output | 1 | Translation result pulse |
| respPa | output | 32 | Physical address |
| respCacheable | output | 1 | Entry marked cacheable |
| respFault | output | 1 | Fault pulse |
| memRdValid | output | 1 | Page table read request |
| memRdAddr | output | 32 | Page table entry address |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 32 | Page table entry |

## Verification
Pass-through, disabled translation, window faults and cache hits all answer on the edge that accepts the request. The bench therefore samples at the falling edge just after that edge. A miss instead shows `memRdValid` and the entry address at that same falling edge. The bench then holds the read for a chosen number of cycles, returns the entry, and samples the result one falling edge after the response edge. A bench-side model of the window, the entry format and the round-robin cache decides ahead of time which of these paths each access must take.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;
  localparam int ADDR_W        = 32;
  localparam int PAGE_SHIFT    = 12;
  localparam int VPN_W         = ADDR_W - PAGE_SHIFT;
  localparam int WIN_MIN_SHIFT = 24;
  localparam int PPN_W         = 19;
  localparam int PTE_PPN_LSB   = 8;
  localparam int PTE_CACHE_BIT = 7;
  localparam int PTE_WR_BIT    = 2;
  localparam int PTE_VALID_BIT = 1;
  localparam int CFG_HI_BIT    = 16;
  localparam int TLB_DATA_W    = PPN_W + 2;

  localparam int REG_CTRL       = 0;
  localparam int REG_BASE       = 1;
  localparam int REG_FLUSH_ALL  = 2;
  localparam int REG_FLUSH_PAGE = 3;
  localparam int SLOT_REG0      = 4;

  typedef struct packed {
    logic latchReq;
    logic useLatched;
    logic emitBypass;
    logic emitPlain;
    logic emitFault;
    logic emitHit;
    logic emitFetched;
    logic startFetch;
    logic install;
  } xlStrobe_t;

  typedef struct packed {
    logic bypassSel;
    logic xlateEn;
    logic inWindow;
    logic hit;
    logic hitWritable;
    logic writeReq;
    logic pteValid;
    logic pteWritable;
    logic flushAny;
  } xlStatus_t;
endpackage

// File: rtl/io_xlate_tlb.sv
module io_xlate_tlb #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 21,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              hit,
  output logic [DATA_W-1:0] hitData,
  input  logic              insertEn,
  input  logic [TAG_W-1:0]  insertTag,
  input  logic [DATA_W-1:0] insertData,
  input  logic              flushAll,
  input  logic              flushPageEn,
  input  logic [TAG_W-1:0]  flushTag
);
  logic [ENTRIES-1:0] hitVec;
  logic [DATA_W-1:0]  entData [ENTRIES];
  logic [IDX_W-1:0]   victim;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              vBit;
    logic [TAG_W-1:0]  tagQ;
    logic [DATA_W-1:0] dataQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vBit  <= 1'b0;
        tagQ  <= '0;
        dataQ <= '0;
      end else begin
        if (insertEn && victim == IDX_W'(e)) begin
          vBit  <= 1'b1;
          tagQ  <= insertTag;
          dataQ <= insertData;
        end
        if (flushAll || (flushPageEn && tagQ == flushTag)) vBit <= 1'b0;
      end
    end
    assign hitVec[e]  = vBit && (tagQ == lookupTag);
    assign entData[e] = dataQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) victim <= '0;
    else if (insertEn) victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
  end

  always_comb begin
    hitData = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (hitVec[e]) hitData = hitData | entData[e];
  end
  assign hit = |hitVec;

  // a page is never cached twice, so lookups match at most one entry
  assert_single_hit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
endmodule

// File: rtl/io_xlate_ctrl.sv
module io_xlate_ctrl import io_xlate_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       memRspValid,
  output logic       memRdValid,
  input  xlStatus_t  st,
  output xlStrobe_t  stb
);
  typedef enum logic {ST_IDLE, ST_FETCH} xlState_e;
  xlState_e state, nextState;
  logic cancelFill;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stb.latchReq = 1'b1;
        if (st.bypassSel)      stb.emitBypass = 1'b1;
        else if (!st.xlateEn)  stb.emitPlain  = 1'b1;
        else if (!st.inWindow) stb.emitFault  = 1'b1;
        else if (st.hit) begin
          if (st.writeReq && !st.hitWritable) stb.emitFault = 1'b1;
          else                                stb.emitHit   = 1'b1;
        end else begin
          stb.startFetch = 1'b1;
          nextState      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        stb.useLatched = 1'b1;
        if (memRspValid) begin
          nextState = ST_IDLE;
          if (!st.pteValid) stb.emitFault = 1'b1;
          else begin
            stb.install = !(cancelFill || st.flushAny);
            if (st.writeReq && !st.pteWritable) stb.emitFault   = 1'b1;
            else                                stb.emitFetched = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cancelFill <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.startFetch)                      cancelFill <= 1'b0;
      else if (state == ST_FETCH && st.flushAny) cancelFill <= 1'b1;
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign memRdValid = (state == ST_FETCH);

  // a flush seen during a fetch must keep that entry out of the cache
  assert_no_fill_after_flush_R14: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH && st.flushAny) |=> !stb.install);
endmodule

// File: rtl/io_xlate_dp.sv
module io_xlate_dp import io_xlate_pkg::*; #(
  parameter int NUM_SLOTS   = 4,
  parameter int TLB_ENTRIES = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int REG_AW = $clog2(SLOT_REG0 + NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic              reqWrite,
  output logic              respValid,
  output logic [ADDR_W-1:0] respPa,
  output logic              respCacheable,
  output logic              respFault,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [ADDR_W-1:0] memRspData,
  input  xlStrobe_t         stb,
  output xlStatus_t         st
);
  logic                 ctrlEn;
  logic [2:0]           ctrlRange;
  logic [ADDR_W-1:0]    baseReg;
  logic [NUM_SLOTS-1:0] cfgBypass, cfgBurst8, cfgBurst16, cfgHiBit;
  logic [ADDR_W-1:0]    latVa;
  logic [SLOT_W-1:0]    latSlot;
  logic                 latWrite;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b0; ctrlRange <= '0; baseReg <= '0;
      cfgBypass <= '0; cfgBurst8 <= '0; cfgBurst16 <= '0; cfgHiBit <= '0;
    end else if (regWrEn) begin
      if (regAddr == REG_AW'(REG_CTRL)) begin
        ctrlEn    <= regWrData[0];
        ctrlRange <= regWrData[4:2];
      end
      if (regAddr == REG_AW'(REG_BASE)) baseReg <= regWrData;
      for (int s = 0; s < NUM_SLOTS; s++)
        if (regAddr == REG_AW'(SLOT_REG0 + s)) begin
          cfgBypass[s]  <= regWrData[0];
          cfgBurst8[s]  <= regWrData[1];
          cfgBurst16[s] <= regWrData[2];
          cfgHiBit[s]   <= regWrData[CFG_HI_BIT];
        end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == REG_AW'(REG_CTRL)) regRdData = {27'd0, ctrlRange, 1'b0, ctrlEn};
    if (regAddr == REG_AW'(REG_BASE)) regRdData = baseReg;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (regAddr == REG_AW'(SLOT_REG0 + s)) begin
        regRdData[0]          = cfgBypass[s];
        regRdData[1]          = cfgBurst8[s];
        regRdData[2]          = cfgBurst16[s];
        regRdData[CFG_HI_BIT] = cfgHiBit[s];
      end
  end

  logic flushAllStb, flushPageStb;
  assign flushAllStb  = regWrEn && regAddr == REG_AW'(REG_FLUSH_ALL);
  assign flushPageStb = regWrEn && regAddr == REG_AW'(REG_FLUSH_PAGE);

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latVa <= '0; latSlot <= '0; latWrite <= 1'b0;
    end else if (stb.latchReq) begin
      latVa <= reqVa; latSlot <= reqSlot; latWrite <= reqWrite;
    end
  end

  logic [ADDR_W-1:0] curVa, winMask, winOffset, entryAddr;
  logic [SLOT_W-1:0] curSlot;
  assign curVa   = stb.useLatched ? latVa    : reqVa;
  assign curSlot = stb.useLatched ? latSlot  : reqSlot;

  // window is anchored at the top of the address space
  assign winMask   = {ADDR_W{1'b1}} << (5'(WIN_MIN_SHIFT) + {2'b00, ctrlRange});
  assign winOffset = curVa & ~winMask;
  assign entryAddr = baseReg + {{(ADDR_W-VPN_W-2){1'b0}}, winOffset[ADDR_W-1:PAGE_SHIFT], 2'b00};

  // translation cache
  logic                  tlbHit;
  logic [TLB_DATA_W-1:0] tlbData, fillData;
  assign fillData = {memRspData[PTE_WR_BIT], memRspData[PTE_CACHE_BIT],
                     memRspData[PTE_PPN_LSB +: PPN_W]};

  io_xlate_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(VPN_W), .DATA_W(TLB_DATA_W)) i_tlb (
    .clk        (clk),
    .rstN       (rstN),
    .lookupTag  (curVa[ADDR_W-1:PAGE_SHIFT]),
    .hit        (tlbHit),
    .hitData    (tlbData),
    .insertEn   (stb.install),
    .insertTag  (latVa[ADDR_W-1:PAGE_SHIFT]),
    .insertData (fillData),
    .flushAll   (flushAllStb),
    .flushPageEn(flushPageStb),
    .flushTag   (regWrData[ADDR_W-1:PAGE_SHIFT])
  );

  always_comb begin
    st             = '0;
    st.bypassSel   = cfgBypass[curSlot];
    st.xlateEn     = ctrlEn;
    st.inWindow    = (curVa & winMask) == winMask;
    st.hit         = tlbHit;
    st.hitWritable = tlbData[TLB_DATA_W-1];
    st.writeReq    = stb.useLatched ? latWrite : reqWrite;
    st.pteValid    = memRspData[PTE_VALID_BIT];
    st.pteWritable = memRspData[PTE_WR_BIT];
    st.flushAny    = flushAllStb || flushPageStb;
  end

  // response and fetch address registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0; respFault <= 1'b0; respPa <= '0;
      respCacheable <= 1'b0; memRdAddr <= '0;
    end else begin
      respValid     <= stb.emitBypass | stb.emitPlain | stb.emitHit | stb.emitFetched;
      respFault     <= stb.emitFault;
      respCacheable <= 1'b0;
      respPa        <= '0;
      if (stb.startFetch) memRdAddr <= entryAddr;
      if (stb.emitBypass)
        respPa <= {1'b0, cfgHiBit[curSlot], curVa[ADDR_W-3:0]};
      else if (stb.emitPlain)
        respPa <= {1'b0, curVa[ADDR_W-2:0]};
      else if (stb.emitHit) begin
        respPa        <= {1'b0, tlbData[PPN_W-1:0], curVa[PAGE_SHIFT-1:0]};
        respCacheable <= tlbData[PPN_W];
      end else if (stb.emitFetched) begin
        respPa        <= {1'b0, memRspData[PTE_PPN_LSB +: PPN_W], latVa[PAGE_SHIFT-1:0]};
        respCacheable <= memRspData[PTE_CACHE_BIT];
      end
    end
  end

  assert_pa_top_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !respPa[ADDR_W-1]);
  assert_fault_alone_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(respValid && respFault));
  assert_window_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchReq && !stb.useLatched && ctrlEn && !st.bypassSel && !st.inWindow) |=> respFault);
  assert_fetch_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.useLatched && !stb.latchReq) |=> $stable(memRdAddr));
endmodule

// File: rtl/io_xlate_unit.sv
module io_xlate_unit import io_xlate_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqSlot,
  input  logic [31:0] reqVa,
  input  logic        reqWrite,
  output logic        respValid,
  output logic [31:0] respPa,
  output logic        respCacheable,
  output logic        respFault,
  output logic        memRdValid,
  output logic [31:0] memRdAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  xlStrobe_t stb;
  xlStatus_t st;

  io_xlate_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .memRspValid(memRspValid),
    .memRdValid (memRdValid),
    .st         (st),
    .stb        (stb)
  );

  io_xlate_dp #(.NUM_SLOTS(4), .TLB_ENTRIES(8)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .reqSlot      (reqSlot),
    .reqVa        (reqVa),
    .reqWrite     (reqWrite),
    .respValid    (respValid),
    .respPa       (respPa),
    .respCacheable(respCacheable),
    .respFault    (respFault),
    .memRdAddr    (memRdAddr),
    .memRspData   (memRspData),
    .stb          (stb),
    .st           (st)
  );

  assert_fetch_answers_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && memRspValid) |=> (respValid || respFault));
  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !reqReady);
endmodule

// File: tb/test_io_xlate_unit.sv
module test_io_xlate_unit;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, reqValid = 0, reqWrite = 0, memRspValid = 0;
  logic [2:0] regAddr = 0;
  logic [1:0] reqSlot = 0;
  logic [31:0] regWrData = 0, reqVa = 0, memRspData = 0;
  logic [31:0] regRdData, respPa, memRdAddr;
  logic reqReady, respValid, respCacheable, respFault, memRdValid;
  int checks = 0, failures = 0;

  // bench model
  logic mEn = 0; logic [2:0] mCode = 0; logic [31:0] mBase = 0;
  logic [31:0] mCfg [4] = '{default: 0};
  logic [19:0] mTag [8]; logic mVld [8] = '{default: 0}; int mRr = 0;

  always #10 clk = ~clk;

  io_xlate_unit i_io_xlate_unit (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pteFor(input logic [31:0] a);
    logic [18:0] ppn = a[20:2] ^ 19'h2B5C3;
    return {5'd0, ppn, a[4], 4'd0, |a[3:2], a[7:2] != 6'h3F, 1'b0};
  endfunction

  function automatic logic [31:0] winStart(input logic [2:0] c);
    return 32'hFFFF_FFFF << (24 + c);
  endfunction

  function automatic int mLookup(input logic [19:0] vpn);
    for (int e = 0; e < 8; e++) if (mVld[e] && mTag[e] == vpn) return e;
    return -1;
  endfunction

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
    case (a)
      0: begin mEn = d[0]; mCode = d[4:2]; end
      1: mBase = d;
      2: for (int e = 0; e < 8; e++) mVld[e] = 0;
      3: for (int e = 0; e < 8; e++) if (mTag[e] == d[31:12]) mVld[e] = 0;
      default: mCfg[a - 4] = d;
    endcase
  endtask

  task automatic regRd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regAddr = a; #1;
    chk(regRdData == exp, tag, regRdData, exp);
  endtask

  // one request; returns 1 if it went to memory
  task automatic access(input int slot, input logic [31:0] va, input logic wr,
                        input int dly, input bit flushMid, input string tag, output bit wasMiss);
    logic [31:0] cfg = mCfg[slot], start = winStart(mCode), pte, expPa, expAddr;
    bit expFault = 0, expMiss = 0, expCache = 0, cancel = 0;
    int e = mLookup(va[31:12]);
    expAddr = mBase + (((va - start) >> 12) << 2);
    pte = pteFor(expAddr);
    if (cfg[0]) expPa = {1'b0, cfg[16], va[29:0]};
    else if (!mEn) expPa = {1'b0, va[30:0]};
    else if ((va & start) != start) expFault = 1;
    else begin
      expMiss = (e < 0);
      expPa = {1'b0, pte[26:8], va[11:0]};
      expCache = pte[7];
      if (!pte[1] || (wr && !pte[2])) expFault = 1;
    end
    @(negedge clk); reqValid = 1; reqSlot = 2'(slot); reqVa = va; reqWrite = wr;
    @(negedge clk); reqValid = 0;
    chk(memRdValid == expMiss, {tag, " R6/R10 memory read"}, 32'(memRdValid), 32'(expMiss));
    if (expMiss && memRdValid) begin
      chk(memRdAddr == expAddr, {tag, " R6 entry address"}, memRdAddr, expAddr);
      chk(!respValid && !respFault, {tag, " R6 no early answer"}, 32'(respValid), 0);
      for (int i = 0; i < dly; i++) begin
        if (flushMid && i == 0) begin
          regWr(3'd2, 32'hA5A5_0000); cancel = 1;
        end else @(negedge clk);
        chk(memRdValid && memRdAddr == expAddr, {tag, " R6 read held"}, memRdAddr, expAddr);
      end
      memRspValid = 1; memRspData = pte;
      @(negedge clk); memRspValid = 0; memRspData = 0;
      if (pte[1] && !cancel) begin mTag[mRr] = va[31:12]; mVld[mRr] = 1; mRr = (mRr + 1) % 8; end
    end
    if (expFault)
      chk(respFault && !respValid, {tag, " fault"}, {respValid, respFault}, 32'b01);
    else
      chk(respValid && !respFault && respPa == expPa && respCacheable == expCache,
          {tag, " result"}, respPa, expPa);
    wasMiss = expMiss;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit m;
    logic [31:0] s, v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady && !respValid && !respFault && !memRdValid, "R1 idle outputs",
        {reqReady, respValid, respFault, memRdValid}, 32'b1000);
    regRd(0, 0, "R1 control"); regRd(1, 0, "R1 base"); regRd(5, 0, "R1 slot");
    // R2 register fields
    regWr(0, 32'hFFFF_FFFF); regRd(0, 32'h1D, "R2 control readback");
    regWr(1, 32'h0004_0000); regRd(1, 32'h0004_0000, "R2 base readback");
    regRd(2, 0, "R2 flush-all reads zero"); regRd(3, 0, "R2 flush-page reads zero");
    // R3 pass-through and burst flags
    regWr(6, 32'hFFFF_FFFF); regRd(6, 32'h0001_0007, "R3 slot readback");
    regWr(0, 32'h1); // window 16 MB, enabled
    access(2, 32'h1234_5678, 1, 0, 0, "R3 bypass hi=1", m);
    regWr(6, 32'h0000_0007);
    access(2, 32'hD234_5678, 0, 0, 0, "R3 bypass hi=0 burst flags", m);
    // R4 disabled
    regWr(0, 32'h0);
    access(0, 32'hDEAD_BEEF, 1, 0, 0, "R4 plain", m);
    chk(!respCacheable, "R4 not cacheable", 32'(respCacheable), 0);
    // R5 window bounds, R1 first access misses
    regWr(0, 32'h1);
    access(0, 32'hFEFF_FFFF, 0, 0, 0, "R5 below window", m);
    access(0, 32'hFF00_0123, 0, 0, 0, "R1 R7 first translated", m);
    chk(m, "R1 cache empty", 32'(m), 1);
    access(0, 32'hFF00_0456, 0, 0, 0, "R10 hit", m);
    chk(!m, "R10 hit no read", 32'(m), 0);
    regWr(0, 32'h1D);
    access(0, 32'h7FFF_FFFF, 0, 0, 0, "R5 below 2GB window", m);
    access(0, 32'h8000_2010, 0, 2, 0, "R6 R7 2GB low page", m);
    // R8 invalid entry (index 63)
    regWr(0, 32'h1); regWr(2, 0);
    access(0, 32'hFF03_F000, 0, 1, 0, "R8 invalid", m);
    access(0, 32'hFF03_F000, 0, 0, 0, "R8 refetch", m);
    chk(m, "R8 not cached", 32'(m), 1);
    // R9 read-only entry (index 4)
    access(0, 32'hFF00_4000, 1, 0, 0, "R9 write to read-only", m);
    access(0, 32'hFF00_4008, 0, 0, 0, "R9 read ok", m);
    access(0, 32'hFF00_400C, 1, 0, 0, "R9 write to cached read-only", m);
    chk(!m, "R9 cached", 32'(m), 0);
    // R11 round robin
    regWr(2, 32'hFFFF_FFFF);
    for (int i = 0; i < 9; i++) access(0, 32'hFF10_0000 + (i << 12), 0, 0, 0, "R11 fill", m);
    access(0, 32'hFF10_8000, 0, 0, 0, "R11 newest kept", m);
    chk(!m, "R11 newest hit", 32'(m), 0);
    access(0, 32'hFF10_0000, 0, 0, 0, "R11 oldest evicted", m);
    chk(m, "R11 evicted miss", 32'(m), 1);
    // R12 flush all
    regWr(2, 32'h0000_1234);
    access(0, 32'hFF10_8000, 0, 0, 0, "R12 after flush", m);
    chk(m, "R12 miss", 32'(m), 1);
    // R13 flush one page
    access(0, 32'hFF20_1000, 0, 0, 0, "R13 fill A", m);
    access(0, 32'hFF20_2000, 0, 0, 0, "R13 fill B", m);
    regWr(3, 32'hFF20_1ABC);
    access(0, 32'hFF20_1000, 0, 0, 0, "R13 A flushed", m);
    chk(m, "R13 A miss", 32'(m), 1);
    access(0, 32'hFF20_2000, 0, 0, 0, "R13 B kept", m);
    chk(!m, "R13 B hit", 32'(m), 0);
    // R14 flush during fetch
    access(0, 32'hFF30_1000, 0, 3, 1, "R14 answer", m);
    access(0, 32'hFF30_1000, 0, 0, 0, "R14 not cached", m);
    chk(m, "R14 refetch", 32'(m), 1);
    // random mix
    for (int r = 0; r < 10; r++) begin
      regWr(0, {27'd0, 3'($urandom % 8), 1'b0, 1'b1});
      regWr(1, {$urandom % 32'h100, 8'h00} << 8);
      regWr(2, $urandom);
      regWr(5, {15'd0, 1'($urandom), 15'd0, 1'b1});
      s = winStart(mCode);
      for (int k = 0; k < 25; k++) begin
        int sel = $urandom % 10;
        if (sel == 0) v = s - 1 - ($urandom % 4096);
        else v = s + (($urandom % 12) << 12) + ($urandom % 4096);
        access(sel == 1 ? 1 : 0, v, 1'($urandom), $urandom % 3, 0, "R5 R6 R7 R10 random", m);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule